// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block owns the low-power state of a small processor core. When the instruction decoder strobes a sleep request, the controller stops the core clock phases. It also drops the oscillator driver enable and tells the watchdog to clear its count, which keeps running. The controller then waits for one of three kinds of wake event: an external reset, a watchdog timeout while the watchdog is enabled, or an interrupt source whose own enable bit is set.

An external reset restarts the device. A watchdog or interrupt wake continues the program. For crystal and low-power oscillator modes, the controller first counts a start-up delay. In RC mode it skips the delay. It then restarts the clock phases and pulses a resume strobe. The core then runs the instruction already prefetched after the sleep instruction. When the wake came from an interrupt and the global interrupt enable is set, the controller also pulses a vector strobe. The core then branches to the interrupt address after that instruction. The global enable never decides whether the device wakes. It only chooses the resume path.

Two status flags record why the device last woke or reset: a power-down flag and a timeout flag. A watchdog timeout while the core is running produces a core reset, and this block drives no external pin for it.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After power-on reset: `pd_o`=1, `to_o`=1, `osc_en_o`=1, `phase_en_o`=1, and `wdt_clr_o`, `core_rst_o`, `wake_resume_o`, `take_vector_o` are all 0.
- R2: A `sleep_req_i` sampled while the core runs (no reset pending, no watchdog timeout) makes the next cycle show `osc_en_o`=0, `phase_en_o`=0, `pd_o`=0, `to_o`=1, and a `wdt_clr_o` pulse exactly one cycle long.
- R3: While asleep, `wdt_timeout_i` with `wdt_en_i`=1 wakes the device and clears `to_o` (leaving `pd_o`=0). With `wdt_en_i`=0 the timeout is ignored and `osc_en_o` stays 0.
- R4: Interrupt source i (bit 0 external pin, bit 1 port change, bit 2 nonvolatile write done) wakes the device only if `irq_en_i[i]`=1, whatever the value of `gie_i`. A pending source with its enable clear leaves `osc_en_o` at 0. An interrupt wake leaves `to_o`=1.
- R5: Oscillator mode codes 0 (LP), 1 (XT) and 2 (HS) insert a start-up delay. `osc_en_o` rises in the cycle after the wake event is sampled, and `wake_resume_o` rises exactly OST_CYCLES clock edges after that sampling edge. Mode code 3 (RC) skips the delay, so `wake_resume_o` rises on the edge that samples the wake.
- R6: `wake_resume_o` is a one-cycle pulse, and `phase_en_o` turns on in the same cycle. `take_vector_o` pulses together with it exactly when the wake included an enabled interrupt and `gie_i`=1 at the resume edge. Otherwise it stays 0, which means resume in line.
- R7: `ext_reset_i` sampled in any state gives, on the next cycle, `core_rst_o`=1, `osc_en_o`=1, `phase_en_o`=0 and no `wake_resume_o`. It aborts any start-up delay and leaves `pd_o` and `to_o` unchanged. The core runs again one cycle after the input is released.
- R8: A watchdog timeout with `wdt_en_i`=1 while the core runs gives a one-cycle `core_rst_o`, with `to_o`=0 and `pd_o`=1.
- R9: Wake events that arrive during the start-up delay are latched and do not restart the delay. An interrupt arriving then still selects the vector, and a watchdog timeout arriving then still clears `to_o`.
- R10: A `sleep_req_i` during sleep or during the start-up delay is ignored. No new `wdt_clr_o` is produced and the delay still ends on time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous |
| sleep_req_i | input | 1 | Sleep strobe from the instruction decoder |
| osc_mode_i | input | 2 | Oscillator mode: 0 LP, 1 XT, 2 HS, 3 RC |
| ext_reset_i | input | 1 | External reset request, active high |
| wdt_en_i | input | 1 | Watchdog enabled |
| wdt_timeout_i | input | 1 | Watchdog timeout event |
| irq_pend_i | input | NUM_IRQ | Pending flags of the wake-capable interrupt sources |
| irq_en_i | input | NUM_IRQ | Individual enables of those sources |
| gie_i | input | 1 | Global interrupt enable |
| osc_en_o | output | 1 | Oscillator driver enable |
| phase_en_o | output | 1 | Core clock phase enable |
| wdt_clr_o | output | 1 | Watchdog counter clear pulse |
| core_rst_o | output | 1 | Core reset |
| wake_resume_o | output | 1 | Resume pulse after wake |
| take_vector_o | output | 1 | Branch to the interrupt address after the next instruction |
| pd_o | output | 1 | Power-down status flag |
| to_o | output | 1 | Timeout status flag |

## Verification
The bench builds the block with OST_CYCLES=6 and NUM_IRQ=3. With a delay that short, it can sweep every oscillator mode code against every wake source and both values of the global enable. The position of the resume edge is checked cycle by cycle in each of these combinations. The short delay also makes it easy to inject events and sleep requests part-way through the delay. Masked sources, a disabled watchdog and resets in each state are driven as separate cases.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

   typedef enum logic [1:0] {
      PS_RUN   = 2'd0,
      PS_SLEEP = 2'd1,
      PS_START = 2'd2
   } pwr_state_e;

   typedef enum logic [1:0] {
      OSC_LP = 2'd0,
      OSC_XT = 2'd1,
      OSC_HS = 2'd2,
      OSC_RC = 2'd3
   } osc_mode_e;

   // Only the RC mode runs without an oscillator start-up delay.
   function automatic logic needs_startup(input logic [1:0] mode);
      return mode != OSC_RC;
   endfunction

endpackage

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
   parameter int NUM_IRQ = 3
) (
   input  logic               wdt_en_i,
   input  logic               wdt_timeout_i,
   input  logic [NUM_IRQ-1:0] irq_pend_i,
   input  logic [NUM_IRQ-1:0] irq_en_i,
   output logic [NUM_IRQ-1:0] src_hit_o,
   output logic               irq_hit_o,
   output logic               wdt_hit_o
);

   generate
      if (NUM_IRQ < 1) begin : g_bad_irq
         $error("NUM_IRQ must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
      assign src_hit_o[i] = irq_pend_i[i] & irq_en_i[i];
   end

   assign irq_hit_o = |src_hit_o;
   assign wdt_hit_o = wdt_en_i & wdt_timeout_i;

endmodule

// File: rtl/pwr_ost_timer.sv
module pwr_ost_timer #(
   parameter int OST_CYCLES = 1024
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic clr_i,
   input  logic run_i,
   output logic expire_o
);

   localparam int CNT_W = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OST_CYCLES - 1);

   generate
      if (OST_CYCLES < 1) begin : g_bad_ost
         $error("OST_CYCLES must be at least 1");
      end

      if (OST_CYCLES == 1) begin : g_single
         // A one-cycle delay needs no count state.
         assign expire_o = run_i;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) begin
               cnt_q <= '0;
            end else if (clr_i) begin
               cnt_q <= '0;
            end else if (run_i && cnt_q != LAST) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign expire_o = run_i & (cnt_q == LAST);

         a_r5_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            cnt_q <= LAST)
            else $error("start-up count beyond its limit");

         a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (run_i && !clr_i && cnt_q != LAST) |=> (cnt_q != '0))
            else $error("start-up count restarted during the delay");
      end
   endgenerate

endmodule

// File: rtl/pwr_status_flags.sv
module pwr_status_flags (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic sleep_enter_i,
   input  logic wdt_wake_i,
   input  logic wdt_reset_i,
   output logic pd_o,
   output logic to_o
);

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) begin
         pd_o <= 1'b1;
         to_o <= 1'b1;
      end else if (wdt_reset_i) begin
         pd_o <= 1'b1;
         to_o <= 1'b0;
      end else if (sleep_enter_i) begin
         pd_o <= 1'b0;
         to_o <= 1'b1;
      end else if (wdt_wake_i) begin
         to_o <= 1'b0;
      end
   end

   a_r3_wake_clears_to: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      wdt_wake_i |=> !to_o)
      else $error("watchdog wake left the timeout flag set");

   a_r8_run_reset_flags: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      wdt_reset_i |=> (pd_o && !to_o))
      else $error("watchdog reset flags wrong");

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
   import pwr_sleep_pkg::*;
#(
   parameter int OST_CYCLES = 1024,
   parameter int NUM_IRQ    = 3
) (
   input  logic               clk_i,
   input  logic               por_n_i,
   input  logic               sleep_req_i,
   input  logic [1:0]         osc_mode_i,
   input  logic               ext_reset_i,
   input  logic               wdt_en_i,
   input  logic               wdt_timeout_i,
   input  logic [NUM_IRQ-1:0] irq_pend_i,
   input  logic [NUM_IRQ-1:0] irq_en_i,
   input  logic               gie_i,
   output logic               osc_en_o,
   output logic               phase_en_o,
   output logic               wdt_clr_o,
   output logic               core_rst_o,
   output logic               wake_resume_o,
   output logic               take_vector_o,
   output logic               pd_o,
   output logic               to_o
);

   pwr_state_e         state_q;
   logic               core_rst_q;
   logic               resume_q;
   logic               vector_q;
   logic               wdt_clr_q;
   logic               irq_lat_q;

   logic [NUM_IRQ-1:0] src_hit;
   logic               irq_hit;
   logic               wdt_hit;
   logic               expire;
   logic               fast_mode;
   logic               wdt_run_rst;
   logic               sleep_go;
   logic               wake_go;
   logic               fast_wake;
   logic               delay_done;
   logic               wdt_wake;

   pwr_wake_detect #(.NUM_IRQ(NUM_IRQ)) u_detect (
      .wdt_en_i      (wdt_en_i),
      .wdt_timeout_i (wdt_timeout_i),
      .irq_pend_i    (irq_pend_i),
      .irq_en_i      (irq_en_i),
      .src_hit_o     (src_hit),
      .irq_hit_o     (irq_hit),
      .wdt_hit_o     (wdt_hit)
   );

   pwr_ost_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
      .clk_i    (clk_i),
      .rst_n_i  (por_n_i),
      .clr_i    (state_q != PS_START),
      .run_i    (state_q == PS_START),
      .expire_o (expire)
   );

   assign fast_mode   = !needs_startup(osc_mode_i);
   assign wdt_run_rst = (state_q == PS_RUN) & wdt_hit & !ext_reset_i;
   assign sleep_go    = (state_q == PS_RUN) & sleep_req_i & !ext_reset_i
                        & !wdt_hit & !core_rst_q;
   assign wake_go     = (state_q == PS_SLEEP) & !ext_reset_i & (wdt_hit | irq_hit);
   assign fast_wake   = wake_go & fast_mode;
   assign delay_done  = (state_q == PS_START) & expire & !ext_reset_i;
   assign wdt_wake    = ((state_q == PS_SLEEP) | (state_q == PS_START))
                        & wdt_hit & !ext_reset_i;

   pwr_status_flags u_flags (
      .clk_i         (clk_i),
      .rst_n_i       (por_n_i),
      .sleep_enter_i (sleep_go),
      .wdt_wake_i    (wdt_wake),
      .wdt_reset_i   (wdt_run_rst),
      .pd_o          (pd_o),
      .to_o          (to_o)
   );

   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) begin
         state_q    <= PS_RUN;
         core_rst_q <= 1'b0;
         resume_q   <= 1'b0;
         vector_q   <= 1'b0;
         wdt_clr_q  <= 1'b0;
         irq_lat_q  <= 1'b0;
      end else if (ext_reset_i) begin
         state_q    <= PS_RUN;
         core_rst_q <= 1'b1;
         resume_q   <= 1'b0;
         vector_q   <= 1'b0;
         wdt_clr_q  <= 1'b0;
         irq_lat_q  <= 1'b0;
      end else begin
         core_rst_q <= wdt_run_rst;
         wdt_clr_q  <= sleep_go;
         resume_q   <= fast_wake | delay_done;
         vector_q   <= gie_i & ((fast_wake & irq_hit)
                               | (delay_done & (irq_lat_q | irq_hit)));
         unique case (state_q)
            PS_RUN: begin
               irq_lat_q <= 1'b0;
               if (sleep_go) state_q <= PS_SLEEP;
            end
            PS_SLEEP: begin
               if (wake_go) begin
                  irq_lat_q <= irq_hit;
                  state_q   <= fast_mode ? PS_RUN : PS_START;
               end
            end
            PS_START: begin
               irq_lat_q <= irq_lat_q | irq_hit;
               if (delay_done) state_q <= PS_RUN;
            end
            default: begin
               irq_lat_q <= 1'b0;
               state_q   <= PS_RUN;
            end
         endcase
      end
   end

   assign osc_en_o      = (state_q != PS_SLEEP);
   assign phase_en_o    = (state_q == PS_RUN) & !core_rst_q;
   assign wdt_clr_o     = wdt_clr_q;
   assign core_rst_o    = core_rst_q;
   assign wake_resume_o = resume_q;
   assign take_vector_o = vector_q;

   a_r2_sleep_entry: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (phase_en_o && sleep_req_i && !ext_reset_i && !(wdt_en_i && wdt_timeout_i))
      |=> (!osc_en_o && !phase_en_o && wdt_clr_o && !pd_o && to_o))
      else $error("sleep entry outputs wrong");

   a_r4_masked_stays_asleep: assert property (@(posedge clk_i) disable iff (!por_n_i)
      (!osc_en_o && !ext_reset_i && !(wdt_en_i && wdt_timeout_i)
       && ((irq_pend_i & irq_en_i) == '0)) |=> !osc_en_o)
      else $error("woke without an enabled source");

   a_r5_no_phase_asleep: assert property (@(posedge clk_i) disable iff (!por_n_i)
      !osc_en_o |-> !phase_en_o)
      else $error("clock phases running with oscillator off");

   a_r6_vector_with_resume: assert property (@(posedge clk_i) disable iff (!por_n_i)
      take_vector_o |-> (wake_resume_o && phase_en_o))
      else $error("vector without resume");

   a_r6_resume_single: assert property (@(posedge clk_i) disable iff (!por_n_i)
      wake_resume_o |=> !wake_resume_o)
      else $error("resume pulse longer than one cycle");

   a_r7_ext_reset: assert property (@(posedge clk_i) disable iff (!por_n_i)
      ext_reset_i |=> (core_rst_o && osc_en_o && !phase_en_o && !wake_resume_o))
      else $error("external reset response wrong");

   a_r10_clear_single: assert property (@(posedge clk_i) disable iff (!por_n_i)
      wdt_clr_o |=> !wdt_clr_o)
      else $error("watchdog clear repeated");

endmodule

// File: tb/pwr_sleep_ctrl_tb_top.sv
module pwr_sleep_ctrl_tb_top;

   localparam int N  = 6;
   localparam int NI = 3;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          sleep_req = 1'b0;
   logic [1:0]    osc_mode = 2'd0;
   logic          ext_reset = 1'b0;
   logic          wdt_en = 1'b0;
   logic          wdt_to = 1'b0;
   logic [NI-1:0] irq_pend = '0;
   logic [NI-1:0] irq_en = '0;
   logic          gie = 1'b0;
   logic osc_en, phase_en, wdt_clr, core_rst, resume, vect, pd, to;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   pwr_sleep_ctrl #(.OST_CYCLES(N), .NUM_IRQ(NI)) dut_i (
      .clk_i(clk), .por_n_i(por_n), .sleep_req_i(sleep_req), .osc_mode_i(osc_mode),
      .ext_reset_i(ext_reset), .wdt_en_i(wdt_en), .wdt_timeout_i(wdt_to),
      .irq_pend_i(irq_pend), .irq_en_i(irq_en), .gie_i(gie),
      .osc_en_o(osc_en), .phase_en_o(phase_en), .wdt_clr_o(wdt_clr),
      .core_rst_o(core_rst), .wake_resume_o(resume), .take_vector_o(vect),
      .pd_o(pd), .to_o(to)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // R2: enter sleep from run
   task automatic go_sleep();
      sleep_req = 1'b1;
      tick();
      sleep_req = 1'b0;
      chk("R2 osc_en", osc_en, 0);
      chk("R2 phase_en", phase_en, 0);
      chk("R2 wdt_clr", wdt_clr, 1);
      chk("R2 pd/to", {pd, to}, 2'b01);
      tick();
      chk("R2 wdt_clr pulse", wdt_clr, 0);
   endtask

   // R3 R4 R5 R6: wake from src (0 = watchdog, 1..NI = interrupt bit src-1)
   task automatic wake_check(input int mode, input int src, input bit g);
      bit early;
      bit exp_vec;
      osc_mode = 2'(mode);
      gie = g;
      if (src == 0) begin
         wdt_en = 1'b1; wdt_to = 1'b1;
      end else begin
         irq_en[src-1] = 1'b1; irq_pend[src-1] = 1'b1;
      end
      tick();
      wdt_en = 1'b0; wdt_to = 1'b0; irq_en = '0; irq_pend = '0;
      exp_vec = (src != 0) && g;
      if (mode == 3) begin
         chk("R5 rc immediate resume", resume, 1);
      end else begin
         chk("R5 osc_en after wake", osc_en, 1);
         chk("R5 no phase during delay", phase_en, 0);
         early = 1'b0;
         for (int k = 1; k <= N; k++) begin
            if (resume) early = 1'b1;
            tick();
         end
         chk("R5 no early resume", early, 0);
         chk("R5 resume at delay end", resume, 1);
      end
      chk("R6 vector choice", vect, exp_vec);
      chk("R6 phase on with resume", phase_en, 1);
      chk("R3 R4 flags after wake", {pd, to}, (src == 0) ? 2'b00 : 2'b01);
      tick();
      chk("R6 resume one cycle", {resume, vect}, 2'b00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      tick();
      tick();
      por_n = 1'b1;
      tick();
      // R1
      chk("R1 flags", {pd, to}, 2'b11);
      chk("R1 run enables", {osc_en, phase_en}, 2'b11);
      chk("R1 pulses idle", {wdt_clr, core_rst, resume, vect}, 4'b0000);

      // R5 R6 R3 R4: sweep modes x sources x global enable
      for (int m = 0; m < 4; m++)
         for (int s = 0; s <= NI; s++)
            for (int g = 0; g < 2; g++) begin
               go_sleep();
               wake_check(m, s, g[0]);
            end

      // R4 masked sources, R3 disabled watchdog, R10 sleep while asleep
      go_sleep();
      gie = 1'b1;
      irq_pend = '1;
      irq_en = '0;
      sleep_req = 1'b1;
      tick(); tick(); tick();
      chk("R4 masked sources ignored", osc_en, 0);
      chk("R10 no clear while asleep", wdt_clr, 0);
      irq_pend = '0;
      sleep_req = 1'b0;
      wdt_to = 1'b1;
      tick(); tick();
      chk("R3 disabled watchdog ignored", osc_en, 0);
      chk("R3 flags untouched", {pd, to}, 2'b01);
      wdt_to = 1'b0;
      wake_check(3, 2, 1'b0);

      // R9 R10: events during the delay
      go_sleep();
      osc_mode = 2'd1;
      gie = 1'b1;
      wdt_en = 1'b1; wdt_to = 1'b1;
      tick();
      wdt_en = 1'b0; wdt_to = 1'b0;
      for (int k = 1; k <= N; k++) begin
         if (k == 2) begin
            irq_pend[0] = 1'b1; irq_en[0] = 1'b1; sleep_req = 1'b1;
         end
         tick();
         if (k == 2) begin
            irq_pend = '0; irq_en = '0; sleep_req = 1'b0;
            chk("R10 sleep ignored in delay", {osc_en, wdt_clr}, 2'b10);
         end
      end
      chk("R9 delay not restarted", resume, 1);
      chk("R9 latched irq takes vector", vect, 1);
      chk("R9 to cleared", to, 0);
      tick();

      // R9 watchdog during delay after interrupt wake
      go_sleep();
      osc_mode = 2'd2;
      gie = 1'b0;
      irq_pend[2] = 1'b1; irq_en[2] = 1'b1;
      tick();
      irq_pend = '0; irq_en = '0;
      for (int k = 1; k <= N; k++) begin
         if (k == 3) begin
            wdt_en = 1'b1; wdt_to = 1'b1;
         end
         tick();
         wdt_en = 1'b0; wdt_to = 1'b0;
      end
      chk("R9 resume on time", {resume, vect}, 2'b10);
      chk("R9 late watchdog clears to", to, 0);
      tick();

      // R7: external reset while asleep
      go_sleep();
      ext_reset = 1'b1;
      tick();
      chk("R7 reset asleep", {core_rst, osc_en, phase_en, resume}, 4'b1100);
      chk("R7 flags kept", {pd, to}, 2'b01);
      ext_reset = 1'b0;
      tick();
      chk("R7 run after release", {core_rst, phase_en}, 2'b01);

      // R7: external reset during the delay
      go_sleep();
      osc_mode = 2'd0;
      gie = 1'b1;
      irq_pend[1] = 1'b1; irq_en[1] = 1'b1;
      tick();
      irq_pend = '0; irq_en = '0;
      tick();
      ext_reset = 1'b1;
      tick();
      ext_reset = 1'b0;
      chk("R7 reset aborts delay", {core_rst, resume}, 2'b10);
      begin
         bit seen = 1'b0;
         for (int k = 0; k < N + 2; k++) begin
            tick();
            if (resume || vect) seen = 1'b1;
         end
         chk("R7 no resume after abort", seen, 0);
      end
      chk("R7 core running", phase_en, 1);

      // R8: watchdog timeout while running
      wdt_en = 1'b1; wdt_to = 1'b1;
      tick();
      wdt_en = 1'b0; wdt_to = 1'b0;
      chk("R8 core reset", {core_rst, phase_en}, 2'b10);
      chk("R8 flags", {pd, to}, 2'b10);
      tick();
      chk("R8 reset one cycle", {core_rst, phase_en}, 2'b01);
      go_sleep();
      wake_check(0, 1, 1'b1);

      finish_run();
   end

endmodule